// File: doc/BRIEF.md
# Dual-Mode Microcontroller Bus Register Interface

This block sits between an 8051-style external data bus and a small register file inside a peripheral. The host puts out a shared byte that carries either the low address or data. It also puts out a separate high address byte, an address latch enable, an active-low chip select, and active-low read and write strobes. The block turns these into an internal register address, a register select, and write and read enables. During a qualified read it drives the addressed register back onto the shared byte.

A static mode pin chooses how registers are addressed. In multiplexed mode (mode low), the register index is the low address byte captured by the address latch enable. The access must also fall inside one 256-byte page: the high address byte is compared against a base page parameter to form an internal select, and that select is combined with the external chip select. In direct mode (mode high), the high address byte is the register index and the external chip select alone qualifies the access. A 256-entry byte store is included so the interface can be exercised end to end.

Top module: `mcu_bus_if`

## Requirements
- R1: While `ale_i` is high at a rising clock edge, the address latch loads `ad_io`. While `ale_i` is low it holds its value. In multiplexed mode `reg_addr_o` shows the latch one clock after loading.
- R2: In multiplexed mode (`mode_i` = 0), `reg_addr_o` equals the latched low address byte and does not follow `addr_hi_i`.
- R3: In multiplexed mode, `reg_sel_o` is 1 only when `addr_hi_i` equals `BASE_PAGE` (default 8'hC0) and `cs_n_i` is 0.
- R4: In direct mode (`mode_i` = 1), `reg_addr_o` equals `addr_hi_i` and `reg_sel_o` equals the inverse of `cs_n_i`, whatever the latch holds.
- R5: When `reg_sel_o` is 1 and `wr_n_i` is 0, `reg_wr_o` is 1 and the byte on `ad_io` is stored at `reg_addr_o` on the rising clock edge.
- R6: When `reg_sel_o` is 1, `rd_n_i` is 0 and `wr_n_i` is 1, `reg_rd_o` is 1 and `ad_io` carries the stored byte at `reg_addr_o` within the same cycle. At all other times the block leaves `ad_io` undriven.
- R7: If both strobes are low during a selected access, the write takes effect, and `reg_rd_o` stays 0.
- R8: After reset every register reads 8'h00 and the address latch holds 8'h00.
- R9: A write strobe with no select (chip select high, or in multiplexed mode a high byte outside the base page) changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = multiplexed low address, 1 = direct high-byte address |
| ale_i | input | 1 | Address latch enable, active high |
| cs_n_i | input | 1 | External chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_hi_i | input | 8 | High address byte |
| ad_io | inout | 8 | Shared low address / data byte |
| reg_addr_o | output | 8 | Internal register index |
| reg_sel_o | output | 1 | Register access selected |
| reg_wr_o | output | 1 | Register write enable |
| reg_rd_o | output | 1 | Register read enable (block drives `ad_io`) |

## Verification
Every register index is written in direct mode with an arithmetic pattern and read back. All indices are then rewritten in multiplexed mode with a second pattern and read in direct mode. This cross-mode pass shows that both address paths reach the same storage and that the latch, not the high byte, supplies the index in multiplexed mode. A zero sweep after reset checks the cleared state. Writes with chip select high, and multiplexed writes with a high byte one bit away from the base page, must leave the stored value unchanged. This separates the two select qualifications. A latch-hold pattern changes the shared bus while the enable is low, and a collision pattern lowers both strobes together to check that the write wins.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
   typedef enum logic {
      MODE_MUXED  = 1'b0,
      MODE_DIRECT = 1'b1
   } mbi_mode_e;

   typedef struct packed {
      logic sel;
      logic wr;
      logic rd;
   } mbi_ctl_t;
endpackage

// File: rtl/mbi_addr_latch.sv
module mbi_addr_latch #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ale_i,
   input  logic [AW-1:0] ad_i,
   output logic [AW-1:0] lat_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat_o <= '0;
      else if (ale_i) lat_o <= ad_i;
   end
endmodule

// File: rtl/mbi_decode.sv
module mbi_decode
   import mbi_pkg::*;
#(
   parameter int          AW        = 8,
   parameter int          HW        = 8,
   parameter logic [HW-1:0] BASE_PAGE = 8'hC0,
   parameter logic [HW-1:0] PAGE_MASK = '1
) (
   input  mbi_mode_e     mode_i,
   input  logic [AW-1:0] lat_i,
   input  logic [HW-1:0] hi_i,
   input  logic          cs_n_i,
   input  logic          rd_n_i,
   input  logic          wr_n_i,
   output logic [AW-1:0] addr_o,
   output mbi_ctl_t      ctl_o
);
   logic page_hit;

   generate
      if (PAGE_MASK == {HW{1'b1}}) begin : g_full_cmp
         assign page_hit = (hi_i == BASE_PAGE);
      end else begin : g_masked_cmp
         assign page_hit = ((hi_i & PAGE_MASK) == (BASE_PAGE & PAGE_MASK));
      end
   endgenerate

   always_comb begin
      if (mode_i == MODE_DIRECT) begin
         addr_o    = hi_i[AW-1:0];
         ctl_o.sel = !cs_n_i;
      end else begin
         addr_o    = lat_i;
         ctl_o.sel = page_hit && !cs_n_i;
      end
      ctl_o.wr = ctl_o.sel && !wr_n_i;
      ctl_o.rd = ctl_o.sel && !rd_n_i && wr_n_i;
   end
endmodule

// File: rtl/mbi_regfile.sv
module mbi_regfile #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i) begin
         mem[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mcu_bus_if.sv
module mcu_bus_if
   import mbi_pkg::*;
#(
   parameter int          AW        = 8,
   parameter int          HW        = 8,
   parameter int          DW        = 8,
   parameter logic [7:0]  BASE_PAGE = 8'hC0,
   parameter logic [7:0]  PAGE_MASK = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_i,
   input  logic          ale_i,
   input  logic          cs_n_i,
   input  logic          rd_n_i,
   input  logic          wr_n_i,
   input  logic [HW-1:0] addr_hi_i,
   inout  wire  [DW-1:0] ad_io,
   output logic [AW-1:0] reg_addr_o,
   output logic          reg_sel_o,
   output logic          reg_wr_o,
   output logic          reg_rd_o
);
   generate
      if (AW > HW) begin : g_bad_aw
         $error("register index wider than high address byte");
      end
      if (AW > DW) begin : g_bad_dw
         $error("low address must fit on the shared bus");
      end
      if (HW != 8) begin : g_bad_hw
         $error("page parameters assume an 8-bit high byte");
      end
   endgenerate

   logic [AW-1:0] lat;
   logic [DW-1:0] rdata;
   mbi_ctl_t      ctl;
   mbi_mode_e     mode;

   assign mode = mbi_mode_e'(mode_i);

   mbi_addr_latch #(.AW(AW)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .ale_i (ale_i),
      .ad_i  (ad_io[AW-1:0]),
      .lat_o (lat)
   );

   mbi_decode #(
      .AW(AW), .HW(HW), .BASE_PAGE(BASE_PAGE), .PAGE_MASK(PAGE_MASK)
   ) u_dec (
      .mode_i (mode),
      .lat_i  (lat),
      .hi_i   (addr_hi_i),
      .cs_n_i (cs_n_i),
      .rd_n_i (rd_n_i),
      .wr_n_i (wr_n_i),
      .addr_o (reg_addr_o),
      .ctl_o  (ctl)
   );

   mbi_regfile #(.AW(AW), .DW(DW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctl.wr),
      .addr_i  (reg_addr_o),
      .wdata_i (ad_io),
      .rdata_o (rdata)
   );

   assign reg_sel_o = ctl.sel;
   assign reg_wr_o  = ctl.wr;
   assign reg_rd_o  = ctl.rd;
   assign ad_io     = ctl.rd ? rdata : {DW{1'bz}};
endmodule

// File: rtl/mcu_bus_if_chk.sv
module mcu_bus_if_chk #(
   parameter int         AW        = 8,
   parameter int         HW        = 8,
   parameter logic [7:0] BASE_PAGE = 8'hC0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_i,
   input logic          ale_i,
   input logic          cs_n_i,
   input logic          rd_n_i,
   input logic          wr_n_i,
   input logic [HW-1:0] addr_hi_i,
   input logic [AW-1:0] reg_addr_o,
   input logic          reg_sel_o,
   input logic          reg_wr_o,
   input logic          reg_rd_o
);
   // R1: latch holds while enable was low at the previous edge
   a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && !$past(mode_i) && !$past(ale_i)) |-> $stable(reg_addr_o));

   // R3: multiplexed select implies page hit and chip select
   a_r3_page_select: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && reg_sel_o) |-> (addr_hi_i == BASE_PAGE && !cs_n_i));

   // R4: direct mode index comes from the high byte
   a_r4_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i |-> (reg_addr_o == addr_hi_i[AW-1:0]));

   // R7: read and write enables never both active
   a_r7_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd_o && reg_wr_o));

   // R9: no write enable without the external chip select
   a_r9_write_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (!cs_n_i && !wr_n_i));
endmodule

bind mcu_bus_if mcu_bus_if_chk #(.AW(AW), .HW(HW), .BASE_PAGE(BASE_PAGE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .ale_i      (ale_i),
   .cs_n_i     (cs_n_i),
   .rd_n_i     (rd_n_i),
   .wr_n_i     (wr_n_i),
   .addr_hi_i  (addr_hi_i),
   .reg_addr_o (reg_addr_o),
   .reg_sel_o  (reg_sel_o),
   .reg_wr_o   (reg_wr_o),
   .reg_rd_o   (reg_rd_o)
);

// File: tb/tb_mcu_bus_if.sv
module tb_mcu_bus_if;
   localparam int         CLK_PERIOD = 10;
   localparam logic [7:0] BASE       = 8'hC0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode = 1'b1;
   logic       ale = 1'b0;
   logic       cs_n = 1'b1;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] hi = 8'h00;
   logic [7:0] drv = 8'h00;
   logic       drv_en = 1'b0;
   wire  [7:0] ad_bus;
   logic [7:0] raddr;
   logic       rsel, rwr, rrd;

   int   n_chk = 0;
   int   n_bad = 0;
   logic done = 1'b0;
   logic [7:0] exp_mem [256];

   assign ad_bus = drv_en ? drv : 8'hzz;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcu_bus_if #(.BASE_PAGE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .ale_i(ale),
      .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_hi_i(hi),
      .ad_io(ad_bus), .reg_addr_o(raddr), .reg_sel_o(rsel),
      .reg_wr_o(rwr), .reg_rd_o(rrd)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic latch_lo(input logic [7:0] lo);
      @(negedge clk);
      ale = 1'b1; drv_en = 1'b1; drv = lo;
      @(negedge clk);
      ale = 1'b0; drv_en = 1'b0;
   endtask

   task automatic bus_write(input logic m, input logic [7:0] h, input logic [7:0] lo,
                            input logic [7:0] d, input logic csn);
      mode = m;
      if (!m) latch_lo(lo);
      @(negedge clk);
      hi = h; drv = d; drv_en = 1'b1; cs_n = csn; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1; drv_en = 1'b0;
   endtask

   task automatic bus_read(input logic m, input logic [7:0] h, input logic [7:0] lo,
                           output logic [7:0] d, output logic act);
      mode = m;
      if (!m) latch_lo(lo);
      @(negedge clk);
      hi = h; drv_en = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
      #1;
      d = ad_bus; act = rrd;
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic       a;
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      chk("R8 idle rd", {31'd0, rrd}, 32'd0);
      mode = 1'b0; @(negedge clk);
      chk("R8 latch", {24'd0, raddr}, 32'd0);
      for (int i = 0; i < 256; i++) begin
         bus_read(1'b1, i[7:0], 8'h00, d, a);
         chk("R8 zero", {24'd0, d}, 32'd0);
      end

      // R4 R5 R6: direct mode sweep
      for (int i = 0; i < 256; i++) begin
         exp_mem[i] = i[7:0] * 8'd7 + 8'd3;
         bus_write(1'b1, i[7:0], 8'h00, exp_mem[i], 1'b0);
      end
      for (int i = 0; i < 256; i++) begin
         bus_read(1'b1, i[7:0], 8'h00, d, a);
         chk("R4 direct data", {24'd0, d}, {24'd0, exp_mem[i]});
         chk("R6 rd enable", {31'd0, a}, 32'd1);
      end

      // R2 R3: multiplexed write sweep, read back in direct mode
      for (int i = 0; i < 256; i++) begin
         exp_mem[i] = ~i[7:0] ^ 8'h33;
         bus_write(1'b0, BASE, i[7:0], exp_mem[i], 1'b0);
      end
      for (int i = 0; i < 256; i += 5) begin
         bus_read(1'b1, i[7:0], 8'h00, d, a);
         chk("R2 mux->direct", {24'd0, d}, {24'd0, exp_mem[i]});
         bus_read(1'b0, BASE, i[7:0], d, a);
         chk("R3 mux read", {24'd0, d}, {24'd0, exp_mem[i]});
      end

      // R9 R3: off-page and no-chip-select writes ignored
      for (int b = 0; b < 8; b++) begin
         bus_write(1'b0, BASE ^ (8'h01 << b), 8'h40 + b[7:0], 8'hEE, 1'b0);
         bus_read(1'b1, 8'h40 + b[7:0], 8'h00, d, a);
         chk("R9 off page", {24'd0, d}, {24'd0, exp_mem[8'h40 + b]});
      end
      bus_write(1'b1, 8'h21, 8'h00, 8'hEE, 1'b1);
      bus_read(1'b1, 8'h21, 8'h00, d, a);
      chk("R9 cs high direct", {24'd0, d}, {24'd0, exp_mem[8'h21]});
      bus_write(1'b0, BASE, 8'h22, 8'hEE, 1'b1);
      bus_read(1'b1, 8'h22, 8'h00, d, a);
      chk("R9 cs high mux", {24'd0, d}, {24'd0, exp_mem[8'h22]});
      @(negedge clk); mode = 1'b0; hi = BASE ^ 8'h80; cs_n = 1'b0; #1;
      chk("R3 sel off page", {31'd0, rsel}, 32'd0);
      hi = BASE; #1;
      chk("R3 sel on page", {31'd0, rsel}, 32'd1);
      cs_n = 1'b1; #1;
      chk("R3 sel no cs", {31'd0, rsel}, 32'd0);

      // R1: latch hold and reload
      latch_lo(8'h12);
      @(negedge clk); drv_en = 1'b1; drv = 8'h99; hi = 8'h55;
      repeat (3) @(negedge clk);
      chk("R1 hold", {24'd0, raddr}, 32'h12);
      chk("R2 ignores hi", {24'd0, raddr}, 32'h12);
      ale = 1'b1; drv = 8'h34;
      @(negedge clk); ale = 1'b0; drv_en = 1'b0;
      chk("R1 reload", {24'd0, raddr}, 32'h34);
      mode = 1'b1; #1;
      chk("R4 direct index", {24'd0, raddr}, 32'h55);
      cs_n = 1'b0; #1;
      chk("R4 direct sel", {31'd0, rsel}, 32'd1);
      cs_n = 1'b1;

      // R7: both strobes low
      @(negedge clk);
      mode = 1'b1; hi = 8'h77; drv = 8'hA5; drv_en = 1'b1; cs_n = 1'b0;
      wr_n = 1'b0; rd_n = 1'b0; #1;
      chk("R7 rd suppressed", {31'd0, rrd}, 32'd0);
      chk("R5 wr enable", {31'd0, rwr}, 32'd1);
      @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1; drv_en = 1'b0;
      exp_mem[8'h77] = 8'hA5;
      bus_read(1'b1, 8'h77, 8'h00, d, a);
      chk("R7 write wins", {24'd0, d}, 32'hA5);

      // R6: idle read enable
      @(negedge clk);
      chk("R6 idle", {31'd0, rrd}, 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule